// File: doc/BRIEF.md
# Out-of-Order Completion Packet Ring

This block tracks a small circular store of command packets with three running positions: an allocation position, a dispatch position and a retirement position. A fetch engine asks for a batch of slots. It is granted as many as are free, up to the amount asked, and it writes each arriving packet header into its slot. A dispatcher walks the ring one slot at a time in allocation order. The execution side may finish dispatched packets in any order.

The ring records each finish in a one-bit-per-slot completion map. It frees slots strictly in order: each cycle, if the slot at the retirement position is marked finished, that slot's mark is cleared, its header is rewritten to the invalid packet type and the retirement position moves on by one. A one-cycle pulse reports every move of the retirement position, so that the surrounding logic can write the read position back to the host and retry a fetch that stalled for lack of space.

Positions are kept one bit wider than the slot address, so a full ring and an empty ring are told apart. A slot's address is its position modulo the ring depth.

Top module: `ocr_ring`

## Requirements
- R1: After reset, all three positions are zero, the free count equals DEPTH, no dispatch is pending, the retire pulse is low, and every slot header reads as the invalid value 16'h0001 (type field in bits 7:0 equal to 1, all other bits zero).
- R2: The grant is zero when no request is made or no slot is free. Otherwise it equals the smaller of the requested count and the free count, and the allocation position grows by the grant at the next clock edge.
- R3: The free count equals DEPTH minus (allocation position minus retirement position), taken modulo 2*DEPTH. It never exceeds DEPTH.
- R4: A dispatch is pending exactly when the dispatch position differs from the allocation position. A take advances the dispatch position by one when a dispatch is pending. A take with nothing pending is ignored.
- R5: A completion strobe is recorded only for a slot lying between the retirement position (inclusive) and the dispatch position (exclusive). A strobe for any other slot is ignored.
- R6: The retirement position advances by exactly one in a cycle in which the slot it addresses is marked complete, and otherwise holds. Completions that arrive out of order therefore wait until every earlier slot has completed.
- R7: A retired slot's header becomes the invalid value 16'h0001 at the same edge at which the retirement position passes it.
- R8: The retire pulse is high for exactly those cycles in which the retirement position differs from its value one cycle earlier.
- R9: A header write lands only in a slot lying between the retirement position (inclusive) and the allocation position (exclusive); writes to other slots are ignored. A retirement of the same slot in the same cycle takes precedence. The dispatch header output shows the header of the slot at the dispatch position.
- R10: An allocation and a retirement in the same cycle both take effect at that edge. The grant is computed from the free count before that edge's retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req | input | 1 | Request a batch of slots this cycle |
| alloc_cnt | input | SLOT_W+1 | Number of slots requested |
| alloc_gnt | output | SLOT_W+1 | Number of slots granted this cycle |
| fill_en | input | 1 | Write a header into a slot |
| fill_slot | input | SLOT_W | Slot address of the header write |
| fill_hdr | input | HDR_W | Header value to write |
| disp_take | input | 1 | Dispatcher consumes the slot at the dispatch position |
| disp_pending | output | 1 | A dispatched-not-yet slot exists |
| disp_hdr | output | HDR_W | Header at the dispatch position |
| cmpl_en | input | 1 | Completion strobe |
| cmpl_slot | input | SLOT_W | Slot address that completed |
| wr_idx | output | SLOT_W+1 | Allocation position |
| dsp_idx | output | SLOT_W+1 | Dispatch position |
| rd_idx | output | SLOT_W+1 | Retirement position |
| free_cnt | output | SLOT_W+1 | Number of free slots |
| retire_adv | output | 1 | Pulse: retirement position moved at the last edge |

## Verification
Allocation and retirement can fall in the same cycle. The bench provokes this by strobing the completion of the head slot one cycle before a large allocation request, so the retirement and the grant meet at one edge. It then judges the grant (the free count before retirement), the new allocation position and the new free count. A second collision is a header write and a retirement on the same slot. Long pseudo-random stretches exercise both collisions, and a behavioural model compares every output on every clock.

// File: rtl/ocr_pkg.sv
package ocr_pkg;

    // Packet type codes carried in bits 7:0 of a slot header
    typedef enum logic [7:0] {
        PT_VENDOR  = 8'd0,
        PT_INVALID = 8'd1,
        PT_KERNEL  = 8'd2,
        PT_BAR_AND = 8'd3,
        PT_AGENT   = 8'd4,
        PT_BAR_OR  = 8'd5
    } pkt_type_e;

    localparam int TYPE_W = 8;

endpackage

// File: rtl/ocr_grant.sv
// Free-count and partial-grant arithmetic (purely combinational)
module ocr_grant #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 5,
    parameter int CNT_W = 5
) (
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             req,
    input  logic [CNT_W-1:0] req_cnt,
    output logic [CNT_W-1:0] free_cnt,
    output logic [CNT_W-1:0] grant
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [IDX_W-1:0] used;

    always_comb begin
        used     = wr_idx - rd_idx;
        free_cnt = DEPTH_C - CNT_W'(used);
        if (!req) begin
            grant = '0;
        end else if (req_cnt < free_cnt) begin
            grant = req_cnt;
        end else begin
            grant = free_cnt;
        end
    end
endmodule

// File: rtl/ocr_bitmap.sv
// Completion map with in-order retirement decision
module ocr_bitmap #(
    parameter int DEPTH  = 16,
    parameter int SLOT_W = 4,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmpl_en,
    input  logic [SLOT_W-1:0] cmpl_slot,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [IDX_W-1:0]  dsp_idx,
    output logic              cmpl_taken,
    output logic              retire_now
);
    typedef struct packed {
        logic [DEPTH-1:0] done;
    } map_t;

    map_t map_d, map_q;

    logic [SLOT_W-1:0] rd_slot;
    logic [SLOT_W-1:0] off;
    logic [IDX_W-1:0]  inflight;

    always_comb begin
        map_d      = map_q;
        rd_slot    = rd_idx[SLOT_W-1:0];
        off        = cmpl_slot - rd_slot;
        inflight   = dsp_idx - rd_idx;
        cmpl_taken = cmpl_en && ({1'b0, off} < inflight);
        retire_now = map_q.done[rd_slot] && (rd_idx != dsp_idx);
        if (cmpl_taken) begin
            map_d.done[cmpl_slot] = 1'b1;
        end
        if (retire_now) begin
            map_d.done[rd_slot] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q <= '0;
        end else begin
            map_q <= map_d;
        end
    end

    // R5: an ignored strobe leaves the map untouched unless a retirement clears a bit
    a_r5_ignored_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_en && !cmpl_taken && !retire_now) |=> $stable(map_q.done));

    // R6: a retirement always removes the head mark
    a_r6_head_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_now && !(cmpl_en && cmpl_slot == rd_slot)) |=> !map_q.done[$past(rd_slot)]);
endmodule

// File: rtl/ocr_hdr.sv
// Per-slot header registers
module ocr_hdr #(
    parameter int DEPTH  = 16,
    parameter int SLOT_W = 4,
    parameter int IDX_W  = 5,
    parameter int HDR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [SLOT_W-1:0] fill_slot,
    input  logic [HDR_W-1:0]  fill_hdr,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              free_en,
    input  logic [SLOT_W-1:0] dsp_slot,
    output logic [HDR_W-1:0]  dsp_hdr
);
    import ocr_pkg::*;

    localparam logic [HDR_W-1:0] INV_HDR = HDR_W'(PT_INVALID);

    typedef struct packed {
        logic [DEPTH-1:0][HDR_W-1:0] slots;
    } hdr_t;

    hdr_t hdr_d, hdr_q;

    logic [SLOT_W-1:0] rd_slot;
    logic [SLOT_W-1:0] off;
    logic [IDX_W-1:0]  used;
    logic              fill_ok;

    always_comb begin
        hdr_d   = hdr_q;
        rd_slot = rd_idx[SLOT_W-1:0];
        off     = fill_slot - rd_slot;
        used    = wr_idx - rd_idx;
        fill_ok = fill_en && ({1'b0, off} < used);
        if (fill_ok) begin
            hdr_d.slots[fill_slot] = fill_hdr;
        end
        if (free_en) begin
            hdr_d.slots[rd_slot] = INV_HDR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                hdr_q.slots[i] <= INV_HDR;
            end
        end else begin
            hdr_q <= hdr_d;
        end
    end

    assign dsp_hdr = hdr_q.slots[dsp_slot];

    // R7: a freed slot reads invalid right after the edge
    a_r7_freed_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        free_en |=> hdr_q.slots[$past(rd_slot)] == INV_HDR);

    // R9: a write outside the allocated window changes nothing but a freed slot
    a_r9_fill_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !fill_ok && !free_en) |=> $stable(hdr_q.slots));
endmodule

// File: rtl/ocr_ring.sv
// Out-of-order completion packet ring: top level
module ocr_ring #(
    parameter int DEPTH = 16,
    parameter int HDR_W = 16,
    localparam int SLOT_W = $clog2(DEPTH),
    localparam int IDX_W  = SLOT_W + 1,
    localparam int CNT_W  = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic [CNT_W-1:0]  alloc_cnt,
    output logic [CNT_W-1:0]  alloc_gnt,
    input  logic              fill_en,
    input  logic [SLOT_W-1:0] fill_slot,
    input  logic [HDR_W-1:0]  fill_hdr,
    input  logic              disp_take,
    output logic              disp_pending,
    output logic [HDR_W-1:0]  disp_hdr,
    input  logic              cmpl_en,
    input  logic [SLOT_W-1:0] cmpl_slot,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [IDX_W-1:0]  dsp_idx,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [CNT_W-1:0]  free_cnt,
    output logic              retire_adv
);
    localparam logic [IDX_W-1:0] ONE_I   = IDX_W'(1);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    typedef struct packed {
        logic [IDX_W-1:0] wr;
        logic [IDX_W-1:0] dsp;
        logic [IDX_W-1:0] rd;
        logic             adv;
    } pos_t;

    pos_t pos_d, pos_q;

    logic [CNT_W-1:0] grant;
    logic [CNT_W-1:0] free_w;
    logic             retire_now;
    logic             cmpl_taken;

    ocr_grant #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_grant (
        .wr_idx  (pos_q.wr),
        .rd_idx  (pos_q.rd),
        .req     (alloc_req),
        .req_cnt (alloc_cnt),
        .free_cnt(free_w),
        .grant   (grant)
    );

    ocr_bitmap #(.DEPTH(DEPTH), .SLOT_W(SLOT_W), .IDX_W(IDX_W)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmpl_en   (cmpl_en),
        .cmpl_slot (cmpl_slot),
        .rd_idx    (pos_q.rd),
        .dsp_idx   (pos_q.dsp),
        .cmpl_taken(cmpl_taken),
        .retire_now(retire_now)
    );

    ocr_hdr #(.DEPTH(DEPTH), .SLOT_W(SLOT_W), .IDX_W(IDX_W), .HDR_W(HDR_W)) u_hdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_en  (fill_en),
        .fill_slot(fill_slot),
        .fill_hdr (fill_hdr),
        .wr_idx   (pos_q.wr),
        .rd_idx   (pos_q.rd),
        .free_en  (retire_now),
        .dsp_slot (pos_q.dsp[SLOT_W-1:0]),
        .dsp_hdr  (disp_hdr)
    );

    always_comb begin
        pos_d     = pos_q;
        pos_d.wr  = pos_q.wr + IDX_W'(grant);
        if (disp_take && (pos_q.dsp != pos_q.wr)) begin
            pos_d.dsp = pos_q.dsp + ONE_I;
        end
        if (retire_now) begin
            pos_d.rd = pos_q.rd + ONE_I;
        end
        pos_d.adv = retire_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign wr_idx       = pos_q.wr;
    assign dsp_idx      = pos_q.dsp;
    assign rd_idx       = pos_q.rd;
    assign free_cnt     = free_w;
    assign alloc_gnt    = grant;
    assign retire_adv   = pos_q.adv;
    assign disp_pending = (pos_q.dsp != pos_q.wr);

    // R2: grant bounded by request and free count
    a_r2_grant_bound: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |-> (alloc_gnt <= alloc_cnt) && (alloc_gnt <= free_cnt));

    // R2: no request, no grant
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_req |-> alloc_gnt == '0);

    // R2 R10: allocation position grows by the grant of the prior cycle
    a_r2_wr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> wr_idx == $past(wr_idx + IDX_W'(alloc_gnt)));

    // R3: the ring never reports more free slots than it has
    a_r3_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= DEPTH_C);

    // R4: dispatch position stays inside the allocated window
    a_r4_dsp_window: assert property (@(posedge clk) disable iff (!rst_n)
        IDX_W'(dsp_idx - rd_idx) <= IDX_W'(wr_idx - rd_idx));

    // R4: a take with nothing pending is ignored
    a_r4_idle_take: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_take && !disp_pending) |=> $stable(dsp_idx));

    // R6: at most one slot retires per cycle
    a_r6_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> IDX_W'(rd_idx - $past(rd_idx)) <= ONE_I);

    // R8: pulse marks exactly the moves of the retirement position
    a_r8_adv_marks_move: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> retire_adv == (rd_idx != $past(rd_idx)));
endmodule

// File: tb/ocr_ring_test.sv
module ocr_ring_test;
    localparam int D = 16;
    localparam int M = 2 * D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_req = 1'b0;
    logic [4:0]  alloc_cnt = '0;
    logic [4:0]  alloc_gnt;
    logic        fill_en = 1'b0;
    logic [3:0]  fill_slot = '0;
    logic [15:0] fill_hdr = '0;
    logic        disp_take = 1'b0;
    logic        disp_pending;
    logic [15:0] disp_hdr;
    logic        cmpl_en = 1'b0;
    logic [3:0]  cmpl_slot = '0;
    logic [4:0]  wr_idx, dsp_idx, rd_idx, free_cnt;
    logic        retire_adv;

    always #2 clk = ~clk;

    ocr_ring #(.DEPTH(D), .HDR_W(16)) uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_cnt(alloc_cnt), .alloc_gnt(alloc_gnt),
        .fill_en(fill_en), .fill_slot(fill_slot), .fill_hdr(fill_hdr),
        .disp_take(disp_take), .disp_pending(disp_pending), .disp_hdr(disp_hdr),
        .cmpl_en(cmpl_en), .cmpl_slot(cmpl_slot),
        .wr_idx(wr_idx), .dsp_idx(dsp_idx), .rd_idx(rd_idx),
        .free_cnt(free_cnt), .retire_adv(retire_adv)
    );

    int checks = 0;
    int fails  = 0;
    bit compare_on = 1'b0;

    // behavioural reference: unbounded positions, plain arrays
    int m_wr, m_rd, m_dsp;
    bit m_adv;
    bit m_done [D];
    int m_hdr  [D];

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int m_free();
        return D - (m_wr - m_rd);
    endfunction

    function automatic int m_grant();
        int f;
        f = m_free();
        if (!alloc_req) return 0;
        return (int'(alloc_cnt) < f) ? int'(alloc_cnt) : f;
    endfunction

    task automatic model_reset();
        m_wr = 0; m_rd = 0; m_dsp = 0; m_adv = 0;
        for (int i = 0; i < D; i++) begin
            m_done[i] = 0;
            m_hdr[i]  = 16'h0001;
        end
    endtask

    initial model_reset();

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int rs, off, g, tk;
            bit ret;
            rs  = m_rd % D;
            ret = (m_rd < m_dsp) && m_done[rs];
            g   = m_grant();
            tk  = (disp_take && (m_dsp != m_wr)) ? 1 : 0;
            if (cmpl_en) begin
                off = (int'(cmpl_slot) - rs + D) % D;
                if (m_rd + off < m_dsp) m_done[cmpl_slot] = 1;
            end
            if (fill_en) begin
                off = (int'(fill_slot) - rs + D) % D;
                if ((m_rd + off < m_wr) && !(ret && int'(fill_slot) == rs))
                    m_hdr[fill_slot] = int'(fill_hdr);
            end
            if (ret) begin
                m_done[rs] = 0;
                m_hdr[rs]  = 16'h0001;
            end
            m_wr  += g;
            m_dsp += tk;
            m_rd  += ret ? 1 : 0;
            m_adv  = ret;
        end
    end

    // compare every output in the middle of every cycle
    always @(negedge clk) begin
        if (rst_n && compare_on) begin
            chk("R2", "wr_idx", int'(wr_idx), m_wr % M);
            chk("R2", "alloc_gnt", int'(alloc_gnt), m_grant());
            chk("R3", "free_cnt", int'(free_cnt), m_free());
            chk("R4", "dsp_idx", int'(dsp_idx), m_dsp % M);
            chk("R4", "disp_pending", int'(disp_pending), (m_dsp != m_wr) ? 1 : 0);
            chk("R6", "rd_idx", int'(rd_idx), m_rd % M);
            chk("R8", "retire_adv", int'(retire_adv), int'(m_adv));
            chk("R7 R9", "disp_hdr", int'(disp_hdr), m_hdr[m_dsp % D]);
        end
    end

    task automatic idle();
        alloc_req = 0; alloc_cnt = '0; fill_en = 0; disp_take = 0; cmpl_en = 0;
    endtask

    task automatic next_cycle();
        @(posedge clk); #1; idle();
    endtask

    task automatic do_alloc(input int n);
        @(posedge clk); #1; idle(); alloc_req = 1; alloc_cnt = 5'(n);
    endtask

    task automatic do_fill(input int s, input int h);
        @(posedge clk); #1; idle(); fill_en = 1; fill_slot = 4'(s); fill_hdr = 16'(h);
    endtask

    task automatic do_take();
        @(posedge clk); #1; idle(); disp_take = 1;
    endtask

    task automatic do_cmpl(input int s);
        @(posedge clk); #1; idle(); cmpl_en = 1; cmpl_slot = 4'(s);
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) next_cycle();
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "wr_idx", int'(wr_idx), 0);
        chk("R1", "rd_idx", int'(rd_idx), 0);
        chk("R1", "dsp_idx", int'(dsp_idx), 0);
        chk("R1", "free_cnt", int'(free_cnt), D);
        chk("R1", "disp_pending", int'(disp_pending), 0);
        chk("R1", "retire_adv", int'(retire_adv), 0);
        chk("R1", "disp_hdr", int'(disp_hdr), 16'h0001);
        compare_on = 1'b1;

        // R9: header write to an unallocated slot is ignored
        do_fill(7, 16'hBEEF);
        // R2: partial grant from an empty ring
        do_alloc(5);
        for (int i = 0; i < 5; i++) do_fill(i, 16'h0100 + i + 2);
        settle(1);
        chk("R9", "disp_hdr slot0", int'(disp_hdr), 16'h0102);
        // R4: three dispatches
        do_take(); do_take(); do_take();
        // R5: completion of an undispatched slot is ignored
        do_cmpl(4);
        settle(3);
        chk("R5", "rd_idx after undispatched strobe", int'(rd_idx), 0);
        // R6: out-of-order completions hold until the head completes
        do_cmpl(2); do_cmpl(1);
        settle(3);
        chk("R6", "rd_idx held", int'(rd_idx), 0);
        do_cmpl(0);
        settle(5);
        chk("R6", "rd_idx after run", int'(rd_idx), 3);
        // R10: retirement and allocation meet at one edge
        do_take();
        do_cmpl(3);
        do_alloc(20);
        @(negedge clk);
        chk("R10", "grant before retire", int'(alloc_gnt), 14);
        settle(1);
        chk("R10", "wr_idx", int'(wr_idx), 19);
        chk("R10", "rd_idx", int'(rd_idx), 4);
        chk("R10", "free_cnt", int'(free_cnt), 1);
        // R2: grant limited then zero when full
        do_alloc(5);
        do_alloc(5);
        @(negedge clk);
        chk("R2", "grant when full", int'(alloc_gnt), 0);
        // R7: after wrap, retired slot 0 reads invalid at the dispatch position
        for (int i = 0; i < 12; i++) do_take();
        settle(1);
        chk("R7", "dsp_idx", int'(dsp_idx), 16);
        chk("R7", "retired slot header", int'(disp_hdr), 16'h0001);
        // R4: drain dispatch, then an idle take is ignored
        for (int i = 0; i < 6; i++) do_take();
        settle(1);
        chk("R4", "disp_pending drained", int'(disp_pending), 0);
        do_take();
        settle(1);
        chk("R4", "idle take", int'(dsp_idx), 20 % M);

        // pseudo-random phase, compared every cycle against the model
        lfsr = 16'hACE1;
        for (int c = 0; c < 6000; c++) begin
            @(posedge clk); #1;
            idle();
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            alloc_req = lfsr[0] & lfsr[3];
            alloc_cnt = {2'b00, lfsr[6:4]};
            disp_take = lfsr[1];
            cmpl_en   = lfsr[2] | lfsr[7];
            cmpl_slot = lfsr[11:8];
            fill_en   = lfsr[12];
            fill_slot = lfsr[15:12] ^ lfsr[3:0];
            fill_hdr  = {lfsr[7:0], lfsr[15:8]};
        end
        settle(2);
        compare_on = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule